// File: doc/BRIEF.md
# Change-of-Flow Trace Buffer

This block keeps a 64-word history of processor bus activity for a debug unit. While the trace is armed, it writes 16-bit words into a circular store. What it writes depends on one of four capture modes. Normal mode keeps one address for each change of program flow. Loop mode does the same, but skips an address that repeats the last one it stored. Detail mode keeps an address word and a data word for every data read or write cycle. Profile mode stops all writes, and the read port then shows the address of the most recently executed instruction.

The processor side classifies each bus cycle before it reaches this block, so the block trusts the cycle-type and flow-kind codes it receives. A separate event strobe from the trigger logic tells the block to store the cycle's data value instead of its address. Software reads the history one word at a time through a read strobe, from the oldest word to the newest, and a count output tells it how many words are valid. Arming the trace again starts a fresh recording.

Top module: `cof_trace_buffer`

## Requirements
- R1: After a synchronous active-low reset, `word_count` is 0, `full` is 0 and `rd_data` is 0.
- R2: In normal mode (`mode`=0), a valid cycle with `cof_kind` 1 (taken branch source), 2 (indexed jump or call target), 3 (return target) or 4 (interrupt vector) stores `bus_addr`. Codes 0, 5 (software-interrupt or debug vector), 6 and 7 store nothing.
- R3: In loop mode (`mode`=1), the same flow kinds are eligible. An eligible address equal to the last address stored in loop mode since arming is not written. Every address that is written becomes the new compare value.
- R4: In detail mode (`mode`=2), a valid cycle with `cyc_kind` 2 (read) or 3 (write) stores two words: `bus_addr` first, then `bus_data`. `cyc_kind` 0 (program fetch) and 1 (free) store nothing.
- R5: In normal and loop modes, a valid cycle with `evt_store` high stores `bus_data` as one word instead of any address, and leaves the loop compare value unchanged.
- R6: In profile mode (`mode`=3), nothing is stored. `rd_data` shows the last `exec_addr` sampled with `exec_valid` (0 after reset), and `rd_en` does not move the read position.
- R7: `word_count` rises by the number of words written and saturates at 64, where `full` is 1. Further writes overwrite the oldest word, and the write position wraps modulo 64.
- R8: While `arm` is low, no word is written and `word_count` holds.
- R9: The cycle in which `arm` rises clears the write position, the count, the read position and the loop compare value. Any capture in that same cycle goes to the fresh buffer.
- R10: Outside profile mode, `rd_data` shows the word at the read position, counted from the oldest stored word, or 0 if the position is at or past `word_count`. Each `rd_en` advances the position by one, modulo 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Trace enable level; its rising edge restarts the recording |
| mode | input | 2 | Capture mode: 0 normal, 1 loop, 2 detail, 3 profile |
| bus_valid | input | 1 | A bus cycle is presented this clock |
| bus_addr | input | 16 | Address of the cycle, already chosen as source, target or vector |
| bus_data | input | 16 | Data of the cycle |
| cyc_kind | input | 2 | 0 program fetch, 1 free, 2 read, 3 write |
| cof_kind | input | 3 | Flow-change kind code (see R2) |
| evt_store | input | 1 | Store this cycle's data word (event-only trigger match) |
| exec_valid | input | 1 | An instruction completed this clock |
| exec_addr | input | 16 | Address of the completed instruction |
| rd_en | input | 1 | Advance the read position by one word |
| rd_data | output | 16 | Word at the read position, or last executed address in profile mode |
| word_count | output | 7 | Number of valid stored words, 0 to 64 |
| full | output | 1 | All 64 words hold valid history |

## Verification
A corrupted write pointer shows up only later, at the read port. The first word after a wrap, or the second half of a detail pair, comes back out of place as soon as software reads that position. A wrong count shows on `word_count` on the clock after the write, and a stale loop compare value shows as a missing or duplicated address at the next eligible repeat. Read-position faults show on `rd_data` right after the `rd_en` edge. A wrong profile register shows at once, because that path is combinational from the register to `rd_data`.

// File: rtl/cftb_pkg.sv
// Package: shared codes for the change-of-flow trace buffer.
// Assumes the processor side supplies the cycle and flow-kind codes below.
package cftb_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'd0,
        MODE_LOOP    = 2'd1,
        MODE_DETAIL  = 2'd2,
        MODE_PROFILE = 2'd3
    } trace_mode_e;

    // Cycle kinds: bit 1 set marks a data access (read or write).
    localparam logic [1:0] CYC_FETCH = 2'd0;
    localparam logic [1:0] CYC_FREE  = 2'd1;
    localparam logic [1:0] CYC_READ  = 2'd2;
    localparam logic [1:0] CYC_WRITE = 2'd3;

    // Flow-change kinds; codes 1..4 are recorded, others are not.
    localparam logic [2:0] COF_NONE     = 3'd0;
    localparam logic [2:0] COF_BRANCH   = 3'd1;
    localparam logic [2:0] COF_INDIRECT = 3'd2;
    localparam logic [2:0] COF_RETURN   = 3'd3;
    localparam logic [2:0] COF_VECTOR   = 3'd4;
    localparam logic [2:0] COF_DBGVEC   = 3'd5;

endpackage

// File: rtl/cftb_capture_filter.sv
// Module: cftb_capture_filter
// Decides, each clock, how many words (0, 1 or 2) go into the trace store
// and what they are, according to the capture mode. Holds the loop-mode
// compare register that suppresses a repeat of the last stored address.
// Assumes bus_addr already carries the address the processor wants kept
// (branch source, jump target, return target or vector).
module cftb_capture_filter
    import cftb_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              arm_rise,
    input  trace_mode_e       mode,
    input  logic              bus_valid,
    input  logic [W-1:0]      bus_addr,
    input  logic [W-1:0]      bus_data,
    input  logic [1:0]        cyc_kind,
    input  logic [2:0]        cof_kind,
    input  logic              evt_store,
    output logic [1:0]        wr_cnt,
    output logic [W-1:0]      wr_w0,
    output logic [W-1:0]      wr_w1
);

    logic         loop_vld_q;
    logic [W-1:0] loop_addr_q;
    logic         cof_ok;
    logic         loop_hit;
    logic         live;
    logic         loop_load;

    // Classify the current cycle against the loop compare value.
    always_comb begin
        live      = arm && bus_valid;
        cof_ok    = (cof_kind == COF_BRANCH) || (cof_kind == COF_INDIRECT) ||
                    (cof_kind == COF_RETURN) || (cof_kind == COF_VECTOR);
        loop_hit  = loop_vld_q && !arm_rise && (bus_addr == loop_addr_q);
        loop_load = live && (mode == MODE_LOOP) && !evt_store && cof_ok && !loop_hit;
    end

    // Select the words to write for the active mode.
    always_comb begin
        wr_cnt = 2'd0;
        wr_w0  = bus_addr;
        wr_w1  = bus_data;
        if (live) begin
            unique case (mode)
                MODE_NORMAL, MODE_LOOP: begin
                    if (evt_store) begin
                        wr_cnt = 2'd1;
                        wr_w0  = bus_data;
                    end else if (cof_ok && !(mode == MODE_LOOP && loop_hit)) begin
                        wr_cnt = 2'd1;
                    end
                end
                MODE_DETAIL: begin
                    if (cyc_kind[1]) wr_cnt = 2'd2;
                end
                default: wr_cnt = 2'd0;
            endcase
        end
    end

    // Track the last address stored in loop mode; re-arming forgets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loop_vld_q  <= 1'b0;
            loop_addr_q <= '0;
        end else if (loop_load) begin
            loop_vld_q  <= 1'b1;
            loop_addr_q <= bus_addr;
        end else if (arm_rise) begin
            loop_vld_q  <= 1'b0;
        end
    end

    // R6: profile mode never writes.
    assert_profile_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PROFILE) |-> (wr_cnt == 2'd0));

    // R4: a two-word write only happens in detail mode.
    assert_detail_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt == 2'd2) |-> (mode == MODE_DETAIL));

    // R3: an address just stored in loop mode is not stored again next clock.
    assert_loop_suppress_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt == 2'd1 && mode == MODE_LOOP && !evt_store && arm) |=>
        !(mode == MODE_LOOP && !arm_rise && !evt_store && bus_addr == $past(bus_addr))
        || (wr_cnt == 2'd0));

endmodule

// File: rtl/cftb_store.sv
// Module: cftb_store
// Circular word store with a write pointer and a saturating count of valid
// words. Takes up to two words per clock (first at the pointer, second just
// after it). Assumes DEPTH is a power of two so the pointer wraps by itself.
module cftb_store #(
    parameter int DEPTH = 64,
    parameter int W     = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_rise,
    input  logic [1:0]    wr_cnt,
    input  logic [W-1:0]  wr_w0,
    input  logic [W-1:0]  wr_w1,
    input  logic [PW-1:0] rd_idx,
    output logic [W-1:0]  rd_word,
    output logic [PW-1:0] wptr,
    output logic [CW-1:0] count,
    output logic          full
);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wptr_q;
    logic [CW-1:0] count_q;
    logic [PW-1:0] base_ptr;
    logic [PW-1:0] next_ptr;
    logic [CW-1:0] base_cnt;
    logic [CW:0]   cnt_sum;

    // Start from a clean pointer and count in the cycle the trace is re-armed.
    always_comb begin
        base_ptr = arm_rise ? '0 : wptr_q;
        base_cnt = arm_rise ? '0 : count_q;
        next_ptr = base_ptr + 1'b1;
        cnt_sum  = {1'b0, base_cnt} + {{(CW - 1){1'b0}}, wr_cnt};
    end

    // Advance the pointer and the saturating count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            count_q <= '0;
        end else begin
            wptr_q  <= base_ptr + {{(PW - 2){1'b0}}, wr_cnt};
            count_q <= (cnt_sum > DEPTH) ? CW'(DEPTH) : cnt_sum[CW-1:0];
        end
    end

    // Write the storage array; contents need no reset since reads are gated.
    always_ff @(posedge clk) begin
        if (wr_cnt != 2'd0) mem_q[base_ptr] <= wr_w0;
        if (wr_cnt == 2'd2) mem_q[next_ptr] <= wr_w1;
    end

    assign rd_word = mem_q[rd_idx];
    assign wptr    = wptr_q;
    assign count   = count_q;
    assign full    = (count_q == CW'(DEPTH));

    // R7: the count never goes past the depth.
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

    // R7: below saturation, the count grows by exactly the words written.
    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_rise && count_q <= CW'(DEPTH - 2)) |=>
        (count_q == $past(count_q) + {{(CW - 2){1'b0}}, $past(wr_cnt)}));

    // R7: once full, the store stays full until re-armed.
    assert_full_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !arm_rise) |=> full);

endmodule

// File: rtl/cftb_read.sv
// Module: cftb_read
// Read side: keeps the read position relative to the oldest stored word,
// forms the store index, and picks what rd_data shows (stored word, zero
// past the valid words, or the last executed address in profile mode).
// Assumes the store reports pointer, count and full for the same clock.
module cftb_read
    import cftb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int W     = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_rise,
    input  trace_mode_e   mode,
    input  logic          rd_en,
    input  logic          exec_valid,
    input  logic [W-1:0]  exec_addr,
    input  logic [PW-1:0] wptr,
    input  logic [CW-1:0] count,
    input  logic          full,
    input  logic [W-1:0]  rd_word,
    output logic [PW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);

    logic [PW-1:0] rd_off_q;
    logic [W-1:0]  last_exec_q;
    logic          step;

    // Map the read position onto the store, starting at the oldest word.
    always_comb begin
        step   = rd_en && (mode != MODE_PROFILE);
        rd_idx = (full ? wptr : '0) + rd_off_q;
        if (mode == MODE_PROFILE)        rd_data = last_exec_q;
        else if ({1'b0, rd_off_q} < count) rd_data = rd_word;
        else                             rd_data = '0;
    end

    // Move the read position; re-arming returns it to the oldest word.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_off_q <= '0;
        else        rd_off_q <= (arm_rise ? '0 : rd_off_q) + {{(PW - 1){1'b0}}, step};
    end

    // Remember the address of the most recently completed instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)          last_exec_q <= '0;
        else if (exec_valid) last_exec_q <= exec_addr;
    end

    // R6: read strobes do not move the position in profile mode.
    assert_profile_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PROFILE && !arm_rise) |=> (rd_off_q == $past(rd_off_q)));

    // R10: a read strobe outside profile mode moves the position by one.
    assert_read_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode != MODE_PROFILE && !arm_rise) |=> (rd_off_q == $past(rd_off_q) + 1'b1));

endmodule

// File: rtl/cof_trace_buffer.sv
// Module: cof_trace_buffer (top)
// 64 x 16 trace memory for a debug unit: captures flow changes, loop-free
// flow changes, full address/data detail or nothing (profile) while armed,
// and serves the history oldest-first through a read strobe.
// Assumes cycle and flow-kind codes are classified upstream.
module cof_trace_buffer
    import cftb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int W     = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     arm,
    input  logic [1:0]               mode,
    input  logic                     bus_valid,
    input  logic [W-1:0]             bus_addr,
    input  logic [W-1:0]             bus_data,
    input  logic [1:0]               cyc_kind,
    input  logic [2:0]               cof_kind,
    input  logic                     evt_store,
    input  logic                     exec_valid,
    input  logic [W-1:0]             exec_addr,
    input  logic                     rd_en,
    output logic [W-1:0]             rd_data,
    output logic [$clog2(DEPTH):0]   word_count,
    output logic                     full
);

    localparam int PW = $clog2(DEPTH);

    trace_mode_e   mode_e;
    logic          arm_q;
    logic          arm_rise;
    logic [1:0]    wr_cnt;
    logic [W-1:0]  wr_w0;
    logic [W-1:0]  wr_w1;
    logic [PW-1:0] rd_idx;
    logic [PW-1:0] wptr;
    logic [W-1:0]  rd_word;

    assign mode_e   = trace_mode_e'(mode);
    assign arm_rise = arm && !arm_q;

    // Remember the previous arm level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= arm;
    end

    cftb_capture_filter #(.W(W)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .arm_rise  (arm_rise),
        .mode      (mode_e),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .cyc_kind  (cyc_kind),
        .cof_kind  (cof_kind),
        .evt_store (evt_store),
        .wr_cnt    (wr_cnt),
        .wr_w0     (wr_w0),
        .wr_w1     (wr_w1)
    );

    cftb_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_rise (arm_rise),
        .wr_cnt   (wr_cnt),
        .wr_w0    (wr_w0),
        .wr_w1    (wr_w1),
        .rd_idx   (rd_idx),
        .rd_word  (rd_word),
        .wptr     (wptr),
        .count    (word_count),
        .full     (full)
    );

    cftb_read #(.DEPTH(DEPTH), .W(W)) u_read (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_rise   (arm_rise),
        .mode       (mode_e),
        .rd_en      (rd_en),
        .exec_valid (exec_valid),
        .exec_addr  (exec_addr),
        .wptr       (wptr),
        .count      (word_count),
        .full       (full),
        .rd_word    (rd_word),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data)
    );

    // R8: a disarmed trace keeps its count.
    assert_hold_disarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (word_count == $past(word_count)));

    // R9: right after arming, at most one capture's worth of words is counted.
    assert_rearm_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        arm_rise |=> (word_count <= 2));

endmodule

// File: tb/cof_trace_buffer_test.sv
// Bench: directed corner cases, then seeded random traffic, all checked
// against a behavioural model of the requirements kept in this file.
module cof_trace_buffer_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        bus_valid = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic [1:0]  cyc_kind = 2'd0;
    logic [2:0]  cof_kind = 3'd0;
    logic        evt_store = 1'b0;
    logic        exec_valid = 1'b0;
    logic [15:0] exec_addr = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic [6:0]  word_count;
    logic        full;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state
    logic [15:0] m_mem [DEPTH];
    int          m_wp = 0, m_cnt = 0, m_off = 0;
    bit          m_lv = 1'b0, m_armp = 1'b0;
    logic [15:0] m_la = '0, m_exec = '0;

    cof_trace_buffer uut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .mode(mode), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_data(bus_data), .cyc_kind(cyc_kind),
        .cof_kind(cof_kind), .evt_store(evt_store), .exec_valid(exec_valid),
        .exec_addr(exec_addr), .rd_en(rd_en), .rd_data(rd_data),
        .word_count(word_count), .full(full)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_rd();
        int oldest;
        if (mode == 2'd3) return m_exec;
        if (m_off >= m_cnt) return 16'h0;
        oldest = (m_cnt == DEPTH) ? m_wp : 0;
        return m_mem[(oldest + m_off) % DEPTH];
    endfunction

    function automatic bit cof_eligible(input logic [2:0] k);
        return (k >= 3'd1) && (k <= 3'd4);
    endfunction

    task automatic m_put(input logic [15:0] w);
        m_mem[m_wp] = w;
        m_wp = (m_wp + 1) % DEPTH;
        if (m_cnt < DEPTH) m_cnt++;
    endtask

    // Apply the effect of the current inputs at the coming clock edge.
    task automatic model_step();
        if (arm && !m_armp) begin
            m_wp = 0; m_cnt = 0; m_off = 0; m_lv = 1'b0;
        end
        if (arm && bus_valid) begin
            case (mode)
                2'd0: if (evt_store) m_put(bus_data);
                      else if (cof_eligible(cof_kind)) m_put(bus_addr);
                2'd1: if (evt_store) m_put(bus_data);
                      else if (cof_eligible(cof_kind) && !(m_lv && bus_addr == m_la)) begin
                          m_put(bus_addr); m_la = bus_addr; m_lv = 1'b1;
                      end
                2'd2: if (cyc_kind[1]) begin m_put(bus_addr); m_put(bus_data); end
                default: ;
            endcase
        end
        if (rd_en && mode != 2'd3) m_off = (m_off + 1) % DEPTH;
        if (exec_valid) m_exec = exec_addr;
        m_armp = arm;
    endtask

    // One clock: model, edge, then compare the ports 1 ns after the edge.
    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
        check("R7 count", int'(word_count), m_cnt);
        check("R7 full", int'(full), int'(m_cnt == DEPTH));
        check(mode == 2'd3 ? "R6 profile read" : "R10 read", int'(rd_data), int'(exp_rd()));
    endtask

    task automatic bus(input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] ck, input logic [2:0] cf, input logic ev);
        bus_valid = 1'b1; bus_addr = a; bus_data = d; cyc_kind = ck; cof_kind = cf; evt_store = ev;
        tick();
        bus_valid = 1'b0; evt_store = 1'b0; cof_kind = 3'd0;
    endtask

    task automatic rd();
        rd_en = 1'b1; tick(); rd_en = 1'b0;
    endtask

    task automatic rearm(input logic [1:0] md);
        arm = 1'b0; tick();
        mode = md; arm = 1'b1; tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        check("R1 count", int'(word_count), 0);
        check("R1 full", int'(full), 0);
        check("R1 rd_data", int'(rd_data), 0);

        // R2: normal mode filters by flow kind
        mode = 2'd0; arm = 1'b1; tick();
        bus(16'h1111, 16'h0, 2'd0, 3'd1, 1'b0);
        bus(16'h2222, 16'h0, 2'd0, 3'd2, 1'b0);
        bus(16'h3333, 16'h0, 2'd0, 3'd3, 1'b0);
        bus(16'h4444, 16'h0, 2'd0, 3'd4, 1'b0);
        bus(16'h5555, 16'h0, 2'd0, 3'd5, 1'b0);
        bus(16'h6666, 16'h0, 2'd0, 3'd0, 1'b0);
        bus(16'h7777, 16'h0, 2'd0, 3'd6, 1'b0);
        check("R2 count", int'(word_count), 4);
        check("R2 first word", int'(rd_data), 16'h1111);
        rd();
        check("R10 next word", int'(rd_data), 16'h2222);
        rd(); rd(); rd();
        check("R10 past newest", int'(rd_data), 0);

        // R9: re-arming clears
        rearm(2'd0);
        check("R9 count", int'(word_count), 0);
        check("R9 rd_data", int'(rd_data), 0);

        // R5: event data store wins over address
        bus(16'hAAAA, 16'hBEEF, 2'd2, 3'd1, 1'b1);
        check("R5 count", int'(word_count), 1);
        check("R5 data word", int'(rd_data), 16'hBEEF);

        // R3: loop suppression
        rearm(2'd1);
        bus(16'h1200, 16'h0, 2'd0, 3'd1, 1'b0);
        bus(16'h1200, 16'h0, 2'd0, 3'd1, 1'b0);
        bus(16'h1200, 16'h9999, 2'd0, 3'd1, 1'b1);
        bus(16'h1200, 16'h0, 2'd0, 3'd1, 1'b0);
        bus(16'h1300, 16'h0, 2'd0, 3'd3, 1'b0);
        bus(16'h1200, 16'h0, 2'd0, 3'd1, 1'b0);
        check("R3 count", int'(word_count), 4);
        check("R3 word0", int'(rd_data), 16'h1200);
        rd(); check("R3 word1", int'(rd_data), 16'h9999);
        rd(); check("R3 word2", int'(rd_data), 16'h1300);

        // R4: detail pairs
        rearm(2'd2);
        bus(16'h4000, 16'h00D1, 2'd2, 3'd0, 1'b0);
        bus(16'h4100, 16'h00E1, 2'd0, 3'd1, 1'b0);
        bus(16'h4200, 16'h00E2, 2'd1, 3'd0, 1'b0);
        bus(16'h4002, 16'h00D2, 2'd3, 3'd0, 1'b0);
        check("R4 count", int'(word_count), 4);
        check("R4 address first", int'(rd_data), 16'h4000);
        rd(); check("R4 data second", int'(rd_data), 16'h00D1);

        // R6: profile mode
        mode = 2'd3;
        exec_valid = 1'b1; exec_addr = 16'h5A5A; tick(); exec_valid = 1'b0;
        check("R6 last exec", int'(rd_data), 16'h5A5A);
        bus(16'h7000, 16'h0, 2'd3, 3'd1, 1'b0);
        check("R6 no store", int'(word_count), 4);
        rd();
        mode = 2'd2; #1;
        check("R6 read position held", int'(rd_data), 16'h00D1);

        // R8: disarmed
        arm = 1'b0; mode = 2'd0; tick();
        bus(16'h7100, 16'h0, 2'd0, 3'd1, 1'b0);
        check("R8 count held", int'(word_count), 4);

        // R7: wrap and saturation
        rearm(2'd0);
        for (int i = 0; i < 70; i++) bus(16'(i), 16'h0, 2'd0, 3'd1, 1'b0);
        check("R7 saturated", int'(word_count), 64);
        check("R7 full", int'(full), 1);
        check("R7 oldest kept", int'(rd_data), 6);
        rd(); check("R7 next oldest", int'(rd_data), 7);

        // Seeded random traffic
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 150 == 0) arm = ~arm;
            if ($urandom % 80 == 0) mode = 2'($urandom % 4);
            bus_valid  = ($urandom % 4) != 0;
            bus_addr   = 16'h1000 + 16'($urandom % 4);
            bus_data   = 16'($urandom);
            cyc_kind   = 2'($urandom % 4);
            cof_kind   = 3'($urandom % 8);
            evt_store  = ($urandom % 10) == 0;
            exec_valid = ($urandom % 3) == 0;
            exec_addr  = 16'($urandom);
            rd_en      = ($urandom % 4) == 0;
            tick();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule